// File: doc/BRIEF.md
# Memory Port Protocol Checker

This block is a passive monitor. It sits on the user side of a burst-capable memory-mapped port, between a master and a memory controller, and watches the port every clock. It drives nothing onto the bus. It watches the two request strobes, the address, the burst length, the burst-start marker, the write data, the controller's ready and the read-data-valid strobe. When the master breaks a rule of the port, it raises a sticky flag for that rule.

Writes and reads are counted differently. A write burst of length N needs N accepted data beats before the next command may begin. A read burst of length N is a single accepted request, and the controller answers it with N data beats. The monitor keeps a count of read beats still owed, so it can spot returned data that nobody asked for. That is the symptom of a master that repeats its read request once per beat. A timeout flags read data that stops arriving.

Top module: `mport_proto_mon`

## Requirements
- R1: In a cycle with `rd_req` or `wr_req` high, a burst length `size` of 0 or above `MAX_SIZE` sets `err_size` at the next clock edge.
- R2: A cycle with `rd_req` and `wr_req` both high sets `err_both` at the next clock edge.
- R3: In the cycle after a stall, the request may still be presented. Here a stall is a cycle with a strobe high and `ready` low. If a strobe, `addr` or `size` differs from the stalled cycle, `err_hold` is set. The same applies to `wdata`, when both cycles are writes. A change of `burst_start` alone is allowed.
- R4: `err_drop` is set when both strobes are low in the cycle after a stall. This means the request was withdrawn.
- R5: An accepted write beat is a cycle with `wr_req` and `ready` high. It begins a burst when no write beats are owed or `burst_start` is high, and it then owes `size-1` further beats. A write burst is still owing beats if `rd_req` is presented, or if `wr_req` is presented with `burst_start`, and either sets `err_wrburst`.
- R6: `rd_pending` rises by `size` for each cycle with `rd_req` and `ready` high. It falls by one for each `rvalid` while it is non-zero. Both changes apply in the same cycle when they coincide.
- R7: `rvalid` seen while `rd_pending` is 0 sets `err_overrun`.
- R8: After reset every flag is 0 and `rd_pending` is 0. Every flag stays set until reset. `err_any` is the OR of all flags.
- R9: `err_timeout` is set after `TMO_CYC` consecutive cycles in which `rd_pending` is non-zero and `rvalid` is low.
- R10: While both strobes are low, `addr`, `size`, `wdata` and `burst_start` have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request strobe |
| wr_req | input | 1 | Write request / write beat strobe |
| addr | input | ADDR_W | Request address |
| size | input | SIZE_W | Burst length in beats |
| burst_start | input | 1 | First-beat marker of a command |
| wdata | input | DATA_W | Write data |
| ready | input | 1 | Controller accepts the presented beat |
| rvalid | input | 1 | Read data beat returned |
| err_size | output | 1 | Sticky: illegal burst length |
| err_both | output | 1 | Sticky: read and write together |
| err_hold | output | 1 | Sticky: request changed while stalled |
| err_drop | output | 1 | Sticky: request withdrawn while stalled |
| err_wrburst | output | 1 | Sticky: new command inside a write burst |
| err_overrun | output | 1 | Sticky: read data beyond expected count |
| err_timeout | output | 1 | Sticky: read data stopped arriving |
| err_any | output | 1 | OR of all sticky flags |
| rd_pending | output | CNT_W | Read beats still owed |

## Verification
The outstanding read count can be raised by an accepted read request and lowered by a returning data beat in the same cycle. The bench provokes this by issuing a second read in exactly the cycle that carries a data beat of the first. The expected count is the old count plus the new length minus one, with no overrun raised. A behavioural reference model checks every cycle, and each rule violation is also injected alone after reset so that only its own flag may be raised.

// File: rtl/mport_mon_pkg.sv
package mport_mon_pkg;

  localparam int N_ERR = 7;

  typedef enum int unsigned {
    E_SIZE = 0,
    E_BOTH = 1,
    E_HOLD = 2,
    E_DROP = 3,
    E_WRB  = 4,
    E_OVR  = 5,
    E_TMO  = 6
  } err_idx_e;

  // burst length is legal only in 1..mx
  function automatic logic size_bad(input int unsigned sz, input int unsigned mx);
    return (sz == 0) || (sz > mx);
  endfunction

  // beats still owed after the first beat of a burst
  function automatic int unsigned burst_rest(input int unsigned sz);
    return (sz == 0) ? 0 : sz - 1;
  endfunction

  // outstanding read count after one cycle
  function automatic int unsigned pend_step(input int unsigned cnt,
                                            input int unsigned add,
                                            input logic take);
    return cnt + add - (take ? 1 : 0);
  endfunction

endpackage

// File: rtl/mport_hold_chk.sv
module mport_hold_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  output logic              hold_ev,
  output logic              drop_ev
);

  logic              rd_q, wr_q, stall_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] wdata_q;
  logic              any_now, moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      stall_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else begin
      rd_q    <= rd_req;
      wr_q    <= wr_req;
      stall_q <= (rd_req | wr_req) & ~ready;
      addr_q  <= addr;
      size_q  <= size;
      wdata_q <= wdata;
    end
  end

  always_comb begin
    any_now = rd_req | wr_req;
    moved   = (rd_req != rd_q) | (wr_req != wr_q) | (addr != addr_q) |
              (size != size_q) | (wr_req & wr_q & (wdata != wdata_q));
    hold_ev = stall_q & any_now & moved;
    drop_ev = stall_q & ~any_now;
  end

  // R4
  drop_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |-> ($past(rd_req || wr_req) && !$past(ready)));

  // R3
  held_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && any_now && !hold_ev) |-> ($stable(addr) && $stable(size)));

endmodule

// File: rtl/mport_wr_trk.sv
module mport_wr_trk
  import mport_mon_pkg::*;
#(
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              burst_start,
  input  logic [SIZE_W-1:0] size,
  input  logic              ready,
  output logic              wrb_ev
);

  logic [SIZE_W-1:0] wr_left;
  logic              beat_ok, opens;

  always_comb begin
    beat_ok = wr_req & ready;
    opens   = (wr_left == '0) | burst_start;
    wrb_ev  = (wr_left != '0) & (rd_req | (wr_req & burst_start));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_left <= '0;
    end else if (beat_ok) begin
      if (opens) wr_left <= SIZE_W'(burst_rest(32'(size)));
      else       wr_left <= wr_left - 1'b1;
    end else if (rd_req && ready) begin
      wr_left <= '0;
    end
  end

  // R5
  wr_last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_left == SIZE_W'(1) && wr_req && ready && !burst_start) |=> (wr_left == '0));

endmodule

// File: rtl/mport_rd_trk.sv
module mport_rd_trk
  import mport_mon_pkg::*;
#(
  parameter int SIZE_W  = 4,
  parameter int CNT_W   = 8,
  parameter int TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              ready,
  input  logic [SIZE_W-1:0] size,
  input  logic              rvalid,
  output logic [CNT_W-1:0]  pend,
  output logic              ovr_ev,
  output logic              tmo_ev
);

  localparam int TW = $clog2(TMO_CYC + 1);

  logic [TW-1:0] idle;
  logic          acc, take, quiet;

  always_comb begin
    acc    = rd_req & ready;
    take   = rvalid & (pend != '0);
    ovr_ev = rvalid & (pend == '0);
    quiet  = (pend != '0) & ~rvalid;
    tmo_ev = quiet & (idle == TW'(TMO_CYC - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      idle <= '0;
    end else begin
      pend <= CNT_W'(pend_step(32'(pend), acc ? 32'(size) : 32'd0, take));
      if (quiet) begin
        if (idle != TW'(TMO_CYC)) idle <= idle + 1'b1;
      end else begin
        idle <= '0;
      end
    end
  end

  // R6
  rd_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ready && !rvalid) |=> (pend == $past(pend) + CNT_W'($past(size))));

  // R7
  ovr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ev && !(rd_req && ready)) |=> (pend == '0));

  // R9
  tmo_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |-> (pend != '0 && $past(pend) != '0));

endmodule

// File: rtl/mport_proto_mon.sv
module mport_proto_mon
  import mport_mon_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int MAX_SIZE = 8,
  parameter int CNT_W    = 8,
  parameter int TMO_CYC  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              burst_start,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  input  logic              rvalid,
  output logic              err_size,
  output logic              err_both,
  output logic              err_hold,
  output logic              err_drop,
  output logic              err_wrburst,
  output logic              err_overrun,
  output logic              err_timeout,
  output logic              err_any,
  output logic [CNT_W-1:0]  rd_pending
);

  logic [N_ERR-1:0] ev, err_q;
  logic size_ev, both_ev, hold_ev, drop_ev, wrb_ev, ovr_ev, tmo_ev;

  mport_hold_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
    .size(size), .wdata(wdata), .ready(ready), .hold_ev(hold_ev), .drop_ev(drop_ev)
  );

  mport_wr_trk #(.SIZE_W(SIZE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .burst_start(burst_start), .size(size), .ready(ready), .wrb_ev(wrb_ev)
  );

  mport_rd_trk #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .ready(ready), .size(size),
    .rvalid(rvalid), .pend(rd_pending), .ovr_ev(ovr_ev), .tmo_ev(tmo_ev)
  );

  always_comb begin
    size_ev = (rd_req | wr_req) & size_bad(32'(size), 32'(MAX_SIZE));
    both_ev = rd_req & wr_req;
    ev         = '0;
    ev[E_SIZE] = size_ev;
    ev[E_BOTH] = both_ev;
    ev[E_HOLD] = hold_ev;
    ev[E_DROP] = drop_ev;
    ev[E_WRB]  = wrb_ev;
    ev[E_OVR]  = ovr_ev;
    ev[E_TMO]  = tmo_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_q | ev;
  end

  assign err_size    = err_q[E_SIZE];
  assign err_both    = err_q[E_BOTH];
  assign err_hold    = err_q[E_HOLD];
  assign err_drop    = err_q[E_DROP];
  assign err_wrburst = err_q[E_WRB];
  assign err_overrun = err_q[E_OVR];
  assign err_timeout = err_q[E_TMO];
  assign err_any     = |err_q;

  // R8
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R1
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req || wr_req) && size == '0) |=> err_size);

  // R2
  both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wr_req) |=> err_both);

endmodule

// File: tb/mport_proto_mon_bench.sv
`timescale 1ns/1ps
module mport_proto_mon_bench;

  localparam int AW = 24, DW = 32, SW = 4, MAXS = 8, CW = 8, TMO = 64;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          rd_req = 0, wr_req = 0, burst_start = 0, ready = 0, rvalid = 0;
  logic [AW-1:0] addr = '0;
  logic [SW-1:0] size = '0;
  logic [DW-1:0] wdata = '0;
  logic          err_size, err_both, err_hold, err_drop, err_wrburst;
  logic          err_overrun, err_timeout, err_any;
  logic [CW-1:0] rd_pending;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mport_proto_mon #(.ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW), .MAX_SIZE(MAXS),
                    .CNT_W(CW), .TMO_CYC(TMO)) u_mport_proto_mon (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
    .size(size), .burst_start(burst_start), .wdata(wdata), .ready(ready),
    .rvalid(rvalid), .err_size(err_size), .err_both(err_both), .err_hold(err_hold),
    .err_drop(err_drop), .err_wrburst(err_wrburst), .err_overrun(err_overrun),
    .err_timeout(err_timeout), .err_any(err_any), .rd_pending(rd_pending)
  );

  function automatic logic [6:0] flags();
    return {err_timeout, err_overrun, err_wrburst, err_drop, err_hold, err_both, err_size};
  endfunction

  // behavioural reference model
  logic [6:0] m_err, m_ev;
  int m_pend, m_wl, m_idle;
  logic p_rd, p_wr, p_stall, m_any;
  logic [AW-1:0] p_addr;
  logic [SW-1:0] p_size;
  logic [DW-1:0] p_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_err = '0; m_pend = 0; m_wl = 0; m_idle = 0;
      p_rd = 0; p_wr = 0; p_stall = 0; p_addr = '0; p_size = '0; p_wd = '0;
    end else begin
      m_any = rd_req || wr_req;
      m_ev = '0;
      m_ev[0] = m_any && (size == 0 || int'(size) > MAXS);
      m_ev[1] = rd_req && wr_req;
      m_ev[2] = p_stall && m_any && (rd_req != p_rd || wr_req != p_wr || addr != p_addr ||
                size != p_size || (wr_req && p_wr && wdata != p_wd));
      m_ev[3] = p_stall && !m_any;
      m_ev[4] = (m_wl > 0) && (rd_req || (wr_req && burst_start));
      m_ev[5] = rvalid && m_pend == 0;
      m_ev[6] = (m_pend > 0) && !rvalid && m_idle == TMO - 1;
      m_err = m_err | m_ev;
      if (m_pend > 0 && !rvalid) begin
        if (m_idle < TMO) m_idle = m_idle + 1;
      end else m_idle = 0;
      if (wr_req && ready) begin
        if (m_wl == 0 || burst_start) m_wl = (size == 0) ? 0 : int'(size) - 1;
        else m_wl = m_wl - 1;
      end else if (rd_req && ready) m_wl = 0;
      m_pend = m_pend + ((rd_req && ready) ? int'(size) : 0) - ((rvalid && m_pend > 0) ? 1 : 0);
      p_rd = rd_req; p_wr = wr_req; p_addr = addr; p_size = size; p_wd = wdata;
      p_stall = m_any && !ready;
    end
    #1;
    n_chk++;
    if (flags() !== m_err || err_any !== (|m_err)) begin
      n_fail++;
      $display("FAIL R8 model flags actual=%b any=%b expected=%b", flags(), err_any, m_err);
    end
    n_chk++;
    if (int'(rd_pending) != m_pend) begin
      n_fail++;
      $display("FAIL R6 model rd_pending actual=%0d expected=%0d", rd_pending, m_pend);
    end
  end

  task automatic cyc(input bit r, input bit w, input logic [AW-1:0] a, input logic [SW-1:0] s,
                     input bit b, input logic [DW-1:0] d, input bit rdy, input bit v);
    rd_req = r; wr_req = w; addr = a; size = s; burst_start = b; wdata = d;
    ready = rdy; rvalid = v;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 24'h5A5, 0, 0, 32'hDEAD, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle(2);
    rst_n = 1;
  endtask

  task automatic chk_flags(input string req, input logic [6:0] exp);
    n_chk++;
    if (flags() !== exp || err_any !== (|exp)) begin
      n_fail++;
      $display("FAIL %s flags actual=%b any=%b expected=%b", req, flags(), err_any, exp);
    end
  endtask

  task automatic chk_pend(input string req, input int exp);
    n_chk++;
    if (int'(rd_pending) != exp) begin
      n_fail++;
      $display("FAIL %s rd_pending actual=%0d expected=%0d", req, rd_pending, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk_flags("R8 reset", 7'b0);
    chk_pend("R8 reset", 0);

    // legal write burst of 4 with a stall; burst_start may change while stalled (R3, R5)
    cyc(0, 1, 24'h100, 4, 1, 32'h11, 0, 0);
    cyc(0, 1, 24'h100, 4, 0, 32'h11, 1, 0);
    cyc(0, 1, 24'h100, 4, 0, 32'h22, 0, 0);
    cyc(0, 1, 24'h100, 4, 0, 32'h22, 1, 0);
    cyc(0, 1, 24'h100, 4, 0, 32'h33, 1, 0);
    cyc(0, 1, 24'h100, 4, 0, 32'h44, 1, 0);
    // idle bus with garbage size is ignored (R10)
    cyc(0, 0, 24'hFFF, 0, 1, 32'h0, 0, 0);
    cyc(0, 0, 24'h123, 15, 0, 32'h9, 1, 0);
    chk_flags("R5 legal write burst", 7'b0);
    chk_flags("R10 idle values ignored", 7'b0);

    // legal read of 3 (R6)
    cyc(1, 0, 24'h200, 3, 1, 0, 1, 0);
    chk_pend("R6 read accepted", 3);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk_pend("R6 two beats back", 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk_pend("R6 drained", 0);

    // read accept coinciding with a returned beat (R6)
    cyc(1, 0, 24'h300, 2, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, 24'h340, 3, 1, 0, 1, 1);
    chk_pend("R6 add and take same cycle", 3);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk_pend("R6 second read drained", 0);
    chk_flags("R7 no overrun on legal traffic", 7'b0);

    // R1 zero size
    do_reset();
    cyc(1, 0, 24'h10, 0, 1, 0, 1, 0);
    idle(1);
    chk_flags("R1 size zero", 7'b0000001);

    // R1 size above maximum (write, single beat presented)
    do_reset();
    cyc(0, 1, 24'h10, 9, 1, 32'h1, 1, 0);
    idle(1);
    chk_flags("R1 size above max", 7'b0000001);

    // R2 both strobes
    do_reset();
    cyc(1, 1, 24'h20, 1, 1, 32'h2, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk_flags("R2 read and write together", 7'b0000010);

    // R3 address moved while stalled
    do_reset();
    cyc(0, 1, 24'h30, 1, 1, 32'h3, 0, 0);
    cyc(0, 1, 24'h34, 1, 1, 32'h3, 1, 0);
    idle(1);
    chk_flags("R3 address changed under stall", 7'b0000100);

    // R3 write data moved while stalled
    do_reset();
    cyc(0, 1, 24'h30, 1, 1, 32'h3, 0, 0);
    cyc(0, 1, 24'h30, 1, 1, 32'h4, 1, 0);
    idle(1);
    chk_flags("R3 wdata changed under stall", 7'b0000100);

    // R4 withdrawn read
    do_reset();
    cyc(1, 0, 24'h40, 2, 1, 0, 0, 0);
    cyc(0, 0, 24'h40, 2, 0, 0, 0, 0);
    idle(1);
    chk_flags("R4 request withdrawn", 7'b0001000);
    chk_pend("R4 nothing accepted", 0);

    // R5 new write command inside a write burst
    do_reset();
    cyc(0, 1, 24'h50, 4, 1, 32'h1, 1, 0);
    cyc(0, 1, 24'h50, 4, 0, 32'h2, 1, 0);
    cyc(0, 1, 24'h60, 1, 1, 32'h3, 1, 0);
    idle(1);
    chk_flags("R5 write burst cut short", 7'b0010000);

    // R7 over-return
    do_reset();
    cyc(1, 0, 24'h70, 2, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk_flags("R7 exact return", 7'b0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    chk_flags("R7 extra read beat", 7'b0100000);
    chk_pend("R7 count stays zero", 0);

    // R9 timeout, and stickiness (R8)
    do_reset();
    cyc(1, 0, 24'h80, 2, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(TMO - 1);
    chk_flags("R9 one cycle before timeout", 7'b0);
    idle(1);
    chk_flags("R9 timeout raised", 7'b1000000);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(3);
    chk_flags("R8 timeout sticky", 7'b1000000);
    do_reset();
    chk_flags("R8 cleared by reset", 7'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule